// File: doc/BRIEF.md
# Extended Program-Memory Byte Load Unit

This unit executes one instruction: a byte load from program memory. The instruction has three encodings. A 24-bit byte pointer addresses the load. The pointer is an 8-bit page register placed above a 16-bit pointer pair. Program memory holds 16-bit words, so the unit splits the byte pointer into two parts. One part is a word address for a synchronous read port. The other is a lane bit that picks the low or high byte of the returned word. The selected byte is written to one entry of a 32-entry, 8-bit register file.

One encoding can post-increment the pointer. The increment covers the full 24-bit value, so a carry out of the 16-bit pair moves into the page register. Every accepted instruction also raises a one-word program-counter advance.

Execution is held by a small state machine with three states:

- `S_IDLE`: waits for `start` with a matching opcode. That cycle asserts `accept` and latches the decode and the pointer. Transition *accept*: `S_IDLE` to `S_FETCH`. Otherwise the machine stays in `S_IDLE`.
- `S_FETCH`: the memory read cycle. `busy` and `mem_rd_en` are high. Transition *issue*: `S_FETCH` to `S_COMMIT`, always.
- `S_COMMIT`: the returned byte is written, the pointer is written back if required, and `pc_adv` pulses. Transition *retire*: `S_COMMIT` to `S_IDLE`, always.

A post-increment load whose destination is one of the pointer's own registers (30 or 31) is flagged as undefined. The unit then gives the loaded byte priority: it writes the register and drops the pointer write-back.

Top module: `pmload_unit`

## Requirements
- R1: Opcode 0x95D8 is the implied form. It writes the loaded byte to register 0 and leaves the pointer unchanged (`ptr_we` stays low).
- R2: An opcode with bits [15:9] = 1001000 and bits [3:0] = 0110 is the explicit form. It writes the loaded byte to the register given by bits [8:4] and leaves the pointer unchanged.
- R3: An opcode with bits [15:9] = 1001000 and bits [3:0] = 0111 is the post-increment form. It writes to register bits [8:4]. In the commit cycle it asserts `ptr_we`, with {`page_out`,`ptr_out`} equal to the latched {page,pointer} plus one. A carry out of the 16-bit pointer goes into the page.
- R4: In the fetch cycle `mem_rd_en` is high and `mem_word_addr` equals the latched 24-bit {page,pointer} shifted right by one.
- R5: Pointer bit 0 = 0 selects `mem_rd_data[7:0]`. Pointer bit 0 = 1 selects `mem_rd_data[15:8]`. The selected byte drives `rf_wdata`.
- R6: A post-increment from 0xFFFFFF gives {`page_out`,`ptr_out`} = 0x000000, with no other indication.
- R7: `pc_adv` pulses for exactly one cycle, the commit cycle, for every accepted form.
- R8: A post-increment load with destination 30 or 31 raises `undef_flag` in the commit cycle. It still writes the loaded byte to that register and keeps `ptr_we` low.
- R9: In `S_IDLE`, a `start` whose opcode matches none of the three forms leaves `accept` low. It causes no memory read, no register write and no pointer write.
- R10: `accept` is high only in `S_IDLE` with a matching `start`. `busy` is high for exactly the following cycle. The commit follows that cycle. `start` is ignored while the machine is in `S_FETCH` or `S_COMMIT`.
- R11: After reset, `busy`, `accept`, `mem_rd_en`, `rf_we`, `ptr_we`, `pc_adv` and `undef_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Instruction word |
| page_in | input | 8 | Current page register (pointer bits 23..16) |
| ptr_in | input | 16 | Current pointer pair (pointer bits 15..0) |
| accept | output | 1 | Matching instruction taken this cycle |
| busy | output | 1 | Fetch cycle in progress |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_word_addr | output | 23 | Program memory word address |
| mem_rd_data | input | 16 | Read word, valid the cycle after the strobe |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 8 | Register file write byte |
| ptr_we | output | 1 | Pointer write-back enable |
| page_out | output | 8 | Incremented page value |
| ptr_out | output | 16 | Incremented pointer pair value |
| pc_adv | output | 1 | Advance program counter by one word |
| undef_flag | output | 1 | Undefined operand combination flagged |

## Verification
The bench builds the unit with its default parameters: an 8-bit page, a 16-bit pointer pair and 16-bit memory words. These widths bring the carry from pointer pair into page, and the full wrap at 0xFFFFFF, within reach of a handful of chosen pointer values. The widths also give one lane bit, so both byte lanes are exercised by alternating pointer parity. A behavioural model tracks the three states and predicts every output on every clock. Directed runs cover each form, the undefined destinations, unmatched opcodes and `start` held high across busy cycles. A random mix of all of these follows.

// File: rtl/pml_pkg.sv
package pml_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {K_NONE, K_IMPL, K_EXPL, K_POST} ld_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_COMMIT} fsm_e;

    localparam logic [15:0] OP_IMPL      = 16'h95D8;
    localparam logic [15:0] OP_FORM_MASK = 16'hFE0F;
    localparam logic [15:0] OP_EXPL      = 16'h9006;
    localparam logic [15:0] OP_POST      = 16'h9007;
endpackage

// File: rtl/pml_decode.sv
module pml_decode
    import pml_pkg::*;
(
    input  logic [15:0]       instr,
    output ld_kind_e          kind,
    output logic [REG_AW-1:0] dest,
    output logic              undef
);
    always_comb begin
        if (instr == OP_IMPL)
            kind = K_IMPL;
        else if ((instr & OP_FORM_MASK) == OP_EXPL)
            kind = K_EXPL;
        else if ((instr & OP_FORM_MASK) == OP_POST)
            kind = K_POST;
        else
            kind = K_NONE;
    end

    // Implied form targets register 0; the others carry a field in bits 8..4.
    assign dest  = (kind == K_IMPL) ? '0 : instr[8:4];
    // Post-increment into the pointer's own registers (30, 31).
    assign undef = (kind == K_POST) && (dest[REG_AW-1:1] == '1);
endmodule

// File: rtl/pml_ptr_incr.sv
module pml_ptr_incr #(
    parameter int PAGE_W    = 8,
    parameter int PTR_W     = 16,
    parameter int LANE_BITS = 1,
    localparam int ADDR_W   = PAGE_W + PTR_W
) (
    input  logic [PAGE_W-1:0]           page,
    input  logic [PTR_W-1:0]            ptr,
    output logic [PAGE_W-1:0]           next_page,
    output logic [PTR_W-1:0]            next_ptr,
    output logic [ADDR_W-LANE_BITS-1:0] word_addr,
    output logic [LANE_BITS-1:0]        lane
);
    logic [ADDR_W-1:0] full;
    logic [ADDR_W-1:0] bumped;

    assign full   = {page, ptr};
    // One adder over the whole concatenation: carry crosses into the page.
    assign bumped = full + {{(ADDR_W-1){1'b0}}, 1'b1};

    assign next_page = bumped[ADDR_W-1:PTR_W];
    assign next_ptr  = bumped[PTR_W-1:0];
    assign word_addr = full[ADDR_W-1:LANE_BITS];
    assign lane      = full[LANE_BITS-1:0];
endmodule

// File: rtl/pml_lane_sel.sv
module pml_lane_sel #(
    parameter int WORD_W    = 16,
    localparam int LANES    = WORD_W / 8,
    localparam int LANE_BITS = $clog2(LANES)
) (
    input  logic [WORD_W-1:0]    word,
    input  logic [LANE_BITS-1:0] lane,
    output logic [7:0]           byte_out
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*8 +: 8];
    end

    assign byte_out = lanes[lane];
endmodule

// File: rtl/pmload_unit.sv
module pmload_unit
    import pml_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int PTR_W      = 16,
    parameter int WORD_W     = 16,
    localparam int ADDR_W    = PAGE_W + PTR_W,
    localparam int LANE_BITS = $clog2(WORD_W / 8),
    localparam int WADDR_W   = ADDR_W - LANE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [15:0]        instr,
    input  logic [PAGE_W-1:0]  page_in,
    input  logic [PTR_W-1:0]   ptr_in,
    output logic               accept,
    output logic               busy,
    output logic               mem_rd_en,
    output logic [WADDR_W-1:0] mem_word_addr,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               rf_we,
    output logic [REG_AW-1:0]  rf_waddr,
    output logic [7:0]         rf_wdata,
    output logic               ptr_we,
    output logic [PAGE_W-1:0]  page_out,
    output logic [PTR_W-1:0]   ptr_out,
    output logic               pc_adv,
    output logic               undef_flag
);
    fsm_e              state, state_nx;
    ld_kind_e          dec_kind, kind_q;
    logic [REG_AW-1:0] dec_dest, dest_q;
    logic              dec_undef, undef_q;
    logic [PAGE_W-1:0] page_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [LANE_BITS-1:0] lane_q;
    logic [WADDR_W-1:0]   waddr_q;

    pml_decode u_dec (
        .instr (instr),
        .kind  (dec_kind),
        .dest  (dec_dest),
        .undef (dec_undef)
    );

    pml_ptr_incr #(.PAGE_W(PAGE_W), .PTR_W(PTR_W), .LANE_BITS(LANE_BITS)) u_inc (
        .page      (page_q),
        .ptr       (ptr_q),
        .next_page (page_out),
        .next_ptr  (ptr_out),
        .word_addr (waddr_q),
        .lane      (lane_q)
    );

    pml_lane_sel #(.WORD_W(WORD_W)) u_lane (
        .word     (mem_rd_data),
        .lane     (lane_q),
        .byte_out (rf_wdata)
    );

    assign accept = (state == S_IDLE) && start && (dec_kind != K_NONE);

    always_comb begin
        unique case (state)
            S_IDLE:   state_nx = accept ? S_FETCH : S_IDLE;
            S_FETCH:  state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register plus the operand latch taken on accept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            kind_q  <= K_NONE;
            dest_q  <= '0;
            undef_q <= 1'b0;
            page_q  <= '0;
            ptr_q   <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                kind_q  <= dec_kind;
                dest_q  <= dec_dest;
                undef_q <= dec_undef;
                page_q  <= page_in;
                ptr_q   <= ptr_in;
            end
        end
    end

    always_comb begin
        busy          = 1'b0;
        mem_rd_en     = 1'b0;
        rf_we         = 1'b0;
        ptr_we        = 1'b0;
        pc_adv        = 1'b0;
        undef_flag    = 1'b0;
        mem_word_addr = waddr_q;
        rf_waddr      = dest_q;
        unique case (state)
            S_IDLE: ;
            S_FETCH: begin
                busy      = 1'b1;
                mem_rd_en = 1'b1;
            end
            S_COMMIT: begin
                rf_we      = 1'b1;
                pc_adv     = 1'b1;
                undef_flag = undef_q;
                // Loaded data wins on the undefined case; pointer held.
                ptr_we     = (kind_q == K_POST) && !undef_q;
            end
            default: ;
        endcase
    end

    a_r10_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && pc_adv));
    a_r7_pc_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> $past(busy));
    a_r8_undef_blocks_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (rf_we && !ptr_we));
    a_r3_ptr_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> ({page_out, ptr_out} == ADDR_W'($past({page_in, ptr_in}, 2) + ADDR_W'(1))));
    a_r1_implied_r0: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(accept && (instr == OP_IMPL), 2)) |-> (rf_waddr == '0));
    a_r9_no_accept_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept && !pc_adv) |=> !busy);
endmodule

// File: tb/tb_pmload_unit.sv
`timescale 1ns/1ps
module tb_pmload_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  page_in = 8'h00;
    logic [15:0] ptr_in = 16'h0000;
    logic        accept, busy, mem_rd_en, rf_we, ptr_we, pc_adv, undef_flag;
    logic [22:0] mem_word_addr;
    logic [15:0] mem_rd_data = 16'h0000;
    logic [4:0]  rf_waddr;
    logic [7:0]  rf_wdata, page_out;
    logic [15:0] ptr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pmload_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .page_in(page_in), .ptr_in(ptr_in), .accept(accept), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_word_addr(mem_word_addr),
        .mem_rd_data(mem_rd_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .ptr_we(ptr_we), .page_out(page_out),
        .ptr_out(ptr_out), .pc_adv(pc_adv), .undef_flag(undef_flag)
    );

    function automatic logic [15:0] memf(input logic [22:0] a);
        logic [7:0] lo, hi;
        lo = a[7:0] ^ 8'h3C;
        hi = a[15:8] + {1'b0, a[22:16]} + 8'h5A;
        return {hi, lo};
    endfunction

    // Synchronous program memory: word appears the cycle after the strobe.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_word_addr);

    // 0 none, 1 implied, 2 explicit, 3 post-increment
    function automatic int kind_of(input logic [15:0] i);
        if (i == 16'h95D8) return 1;
        if (i[15:9] == 7'b1001000 && i[3:0] == 4'b0110) return 2;
        if (i[15:9] == 7'b1001000 && i[3:0] == 4'b0111) return 3;
        return 0;
    endfunction

    // Behavioural reference model
    int          m_phase = 0;
    int          m_kind = 0;
    int          m_dest = 0;
    logic [23:0] m_addr = 24'h0;

    always @(posedge clk) begin
        if (!rst_n) m_phase = 0;
        else begin
            case (m_phase)
                0: if (start && kind_of(instr) != 0) begin
                       m_kind  = kind_of(instr);
                       m_dest  = (m_kind == 1) ? 0 : int'(instr[8:4]);
                       m_addr  = {page_in, ptr_in};
                       m_phase = 1;
                   end
                1: m_phase = 2;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [23:0] nxt;
            logic [15:0] w;
            bit          und;
            nxt = m_addr + 24'd1;
            w   = memf(m_addr[23:1]);
            und = (m_kind == 3) && (m_dest >= 30);
            case (m_phase)
                0: begin
                    check(kind_of(instr) == 0 && start ? "R9 accept" : "R10 accept",
                          32'(accept), 32'(start && kind_of(instr) != 0));
                    check("R10 busy idle", 32'(busy), 0);
                    check("R9 rd_en idle", 32'(mem_rd_en), 0);
                    check("R9 rf_we idle", 32'(rf_we), 0);
                    check("R9 ptr_we idle", 32'(ptr_we), 0);
                    check("R7 pc_adv idle", 32'(pc_adv), 0);
                end
                1: begin
                    check("R10 accept busy", 32'(accept), 0);
                    check("R10 busy", 32'(busy), 1);
                    check("R4 rd_en", 32'(mem_rd_en), 1);
                    check("R4 word addr", 32'(mem_word_addr), 32'(m_addr[23:1]));
                    check("R7 pc_adv fetch", 32'(pc_adv), 0);
                    check("R10 rf_we fetch", 32'(rf_we), 0);
                end
                default: begin
                    check("R10 accept commit", 32'(accept), 0);
                    check("R10 busy commit", 32'(busy), 0);
                    check("R7 pc_adv", 32'(pc_adv), 1);
                    check(m_kind == 1 ? "R1 rf_we" : (m_kind == 2 ? "R2 rf_we" : "R3 rf_we"),
                          32'(rf_we), 1);
                    check(m_kind == 1 ? "R1 dest" : (m_kind == 2 ? "R2 dest" : "R3 dest"),
                          32'(rf_waddr), 32'(m_dest));
                    check("R5 lane byte", 32'(rf_wdata), 32'(m_addr[0] ? w[15:8] : w[7:0]));
                    check("R8 undef", 32'(undef_flag), 32'(und));
                    check(und ? "R8 ptr_we" : "R3 ptr_we", 32'(ptr_we), 32'(m_kind == 3 && !und));
                    if (m_kind == 3 && !und)
                        check(m_addr == 24'hFFFFFF ? "R6 wrap" : "R3 next ptr",
                              32'({page_out, ptr_out}), 32'(nxt));
                end
            endcase
        end
    end

    task automatic issue(input logic [15:0] op, input logic [7:0] pg, input logic [15:0] p);
        @(posedge clk); #1;
        start = 1'b1; instr = op; page_in = pg; ptr_in = p;
        @(posedge clk); #1;
        start = 1'b0;
        // Scramble inputs during the busy cycles; they must not matter.
        instr = 16'h95D8; page_in = ~pg; ptr_in = ~p;
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [15:0] op_of(input int k, input int d);
        case (k)
            1: return 16'h95D8;
            2: return {7'b1001000, 5'(d), 4'b0110};
            default: return {7'b1001000, 5'(d), 4'b0111};
        endcase
    endfunction

    initial begin
        #1;
        // R11 reset state
        check("R11 busy", 32'(busy), 0);
        check("R11 accept", 32'(accept), 0);
        check("R11 rd_en", 32'(mem_rd_en), 0);
        check("R11 rf_we", 32'(rf_we), 0);
        check("R11 ptr_we", 32'(ptr_we), 0);
        check("R11 pc_adv", 32'(pc_adv), 0);
        check("R11 undef", 32'(undef_flag), 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        issue(op_of(1, 0), 8'h01, 16'h2344);           // R1 even lane
        issue(op_of(1, 0), 8'h7F, 16'h0ABB);           // R1 odd lane, R5
        issue(op_of(2, 5), 8'h00, 16'h1000);           // R2
        issue(op_of(2, 31), 8'h33, 16'h5555);          // R2 into 31 is defined
        issue(op_of(3, 12), 8'h12, 16'hFFFF);          // R3 carry into page
        issue(op_of(3, 7), 8'h40, 16'h00FE);           // R3 plain
        issue(op_of(3, 9), 8'hFF, 16'hFFFF);           // R6 wrap
        issue(op_of(3, 30), 8'h05, 16'h0101);          // R8
        issue(op_of(3, 31), 8'h06, 16'h0202);          // R8
        issue(16'h95C8, 8'h01, 16'h0001);              // R9
        issue(16'h9004, 8'h01, 16'h0001);              // R9
        issue(16'h0000, 8'h01, 16'h0001);              // R9

        // R10: start held high across busy cycles; only idle cycles accept
        @(posedge clk); #1;
        start = 1'b1; instr = op_of(3, 3); page_in = 8'h22; ptr_in = 16'hFFFE;
        repeat (7) @(posedge clk);
        #1 start = 1'b0;
        repeat (3) @(posedge clk);

        for (int n = 0; n < 60; n++) begin
            int k;
            k = int'($urandom_range(0, 3));
            issue(k == 0 ? 16'($urandom) : op_of(k, int'($urandom_range(0, 31))),
                  8'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule